// File: doc/BRIEF.md
# Processor Fault Routing and Escalation Unit

This block sits beside a processor pipeline and turns raw fault events into handler requests. Each cycle it takes a vector of per-cause fault strobes and qualifies them against the trap enables and the execute-stage conditions. It records every qualified cause in a sticky status register and sorts the synchronous causes into four handler classes: hard, memory-management, bus and usage. Each configurable class has a handler enable and a numeric priority. When the handler is disabled, or its priority is not more urgent than the current execution priority, the fault is escalated to the hard-fault handler and a forced-escalation flag is recorded.

Imprecise data bus errors are never taken in the cycle they arrive. They are held pending and issued later as bus-class requests, only when the bus handler may preempt the current priority. Per-category debug catch enables turn a fault into a one-cycle debug-halt pulse in place of a handler request. The status flags still record the primary cause.

The exception request leaves on a valid/ready channel. Once raised, valid holds with a stable class until ready is sampled high. While a request waits, newly arriving synchronous faults are recorded in the status register, but they are not routed. Debug-halt pulses do not wait for the channel. Priorities use a low-is-urgent scale. A configurable priority p counts as level p+1. Hard fault is level 0. The current priority input uses the same scale: 0 means the hard-fault handler is active, and 2^PRIO_W means no handler is active.

Top module: `fault_route_unit`

## Requirements
- R1: Flag/cause bit positions: 0 vector-read error, 1 forced escalation (input bit ignored), 2 protection data violation, 3 protection instruction violation, 4 protection violation on save, 5 protection violation on restore, 6 fetch bus error, 7 precise data bus error, 8 imprecise data bus error, 9 bus error on save, 10 bus error on restore, 11 undefined instruction, 12 invalid state, 13 invalid exception return, 14 unaligned access, 15 divide by zero, 16 missing coprocessor. Class codes are 0 hard, 1 memory-management (bits 2-5), 2 bus (bits 6-10), 3 usage (bits 11-16). Handler enable bits are [0] memory-management, [1] bus and [2] usage. A non-escalated synchronous fault raises exc_valid_o, with its class, in the cycle after it is presented.
- R2: Cause bit 0 always requests class 0 and sets only status bit 0 (no forced flag).
- R3: Save and restore failures set their own flags (4, 5, 9, 10). Protection failures route to class 1 and bus failures route to class 2.
- R4: A fault of class 1-3 escalates when its handler enable is 0 or when prio+1 >= cur_prio_i. It is then requested as class 0 and sets status bit 1. This includes cur_prio_i = 0.
- R5: Cause bit 8 sets status bit 8 and imp_pend_o one cycle later and raises no request in that cycle. From the next cycle it is issued as a class-2 request once the slot is free, no synchronous fault is presented, the bus handler is enabled and bus prio+1 < cur_prio_i. Issuing clears imp_pend_o. Until then it stays pending. It never sets bit 1.
- R6: A fetch bus error presented with ex_killed_i high is dropped: no flag and no request.
- R7: ua_multi_i always raises cause 14. Cause bit 14 (single access) raises it only when trap_unalign_i is 1.
- R8: Cause bit 15 has effect only when trap_div0_i is 1.
- R9: Catch enable bits are 0 reset, 1 vector-read or save/restore errors, 2 escalated faults, 3 protection violations, 4 bus errors (6, 7, 8), 5 coprocessor, 6 state errors (11, 12, 13) and 7 check errors (14, 15). A caught winning fault pulses dbg_halt_o for one cycle instead of requesting, and its flag is still set. With bit 0 set, dbg_halt_o pulses in the first cycle after reset.
- R10: Status flags are sticky and cleared by writing one to flag_clr_i. A flag being set in the same cycle wins over its clear.
- R11: When several synchronous classes are presented together, only the one with the lowest level is taken (escalated counts as level 0). Ties go in the order hard, memory-management, bus, usage. The flags of all of them are still recorded.
- R12: While exc_valid_o is high and exc_ready_i is low, exc_valid_o and exc_class_o hold. Faults arriving then set flags but are not routed.
- R13: Under reset, exc_valid_o, dbg_halt_o, status_o and imp_pend_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cause_i | input | 17 | Per-cause fault strobes |
| ua_multi_i | input | 1 | Multi-word access to a non-word-aligned address |
| trap_unalign_i | input | 1 | Trap enable for single unaligned accesses |
| trap_div0_i | input | 1 | Trap enable for a zero divisor |
| ex_killed_i | input | 1 | Instruction at execute is a discarded branch-shadow slot |
| hnd_en_i | input | 3 | Handler enables for memory-management, bus and usage |
| prio_mem_i | input | PRIO_W | Memory-management handler priority |
| prio_bus_i | input | PRIO_W | Bus handler priority |
| prio_use_i | input | PRIO_W | Usage handler priority |
| cur_prio_i | input | PRIO_W+1 | Current execution priority level |
| catch_en_i | input | 8 | Debug catch enables per category |
| flag_clr_i | input | 17 | Write-one-to-clear for status flags |
| exc_valid_o | output | 1 | Exception request valid |
| exc_ready_i | input | 1 | Exception request accepted |
| exc_class_o | output | 2 | Handler class of the request |
| dbg_halt_o | output | 1 | Debug-halt request pulse |
| status_o | output | 17 | Sticky fault status flags |
| imp_pend_o | output | 1 | Imprecise bus error pending |

## Verification
A pending imprecise error and a fresh synchronous fault can both be eligible for the same request slot in one cycle. The bench provokes this by holding an imprecise error pending behind a disabled bus handler, then enabling the handler in the same cycle that an undefined-instruction fault is presented. The bench expects a usage request first, the pending bit to survive, and the bus request to appear one cycle later. Same-cycle arbitration among synchronous classes is swept over the priority combinations, with the winner computed from the level and tie rules.

// File: rtl/fru_pkg.sv
package fru_pkg;
  localparam int NF   = 17;
  localparam int NCAT = 8;

  localparam int F_VEC     = 0;
  localparam int F_FORCED  = 1;
  localparam int F_MDATA   = 2;
  localparam int F_MINSTR  = 3;
  localparam int F_MSAVE   = 4;
  localparam int F_MREST   = 5;
  localparam int F_BFETCH  = 6;
  localparam int F_BPREC   = 7;
  localparam int F_BIMP    = 8;
  localparam int F_BSAVE   = 9;
  localparam int F_BREST   = 10;
  localparam int F_UNDEF   = 11;
  localparam int F_STATE   = 12;
  localparam int F_RET     = 13;
  localparam int F_UNALIGN = 14;
  localparam int F_DIV0    = 15;
  localparam int F_NOCP    = 16;

  localparam int C_RESET = 0;
  localparam int C_STACK = 1;
  localparam int C_HARD  = 2;
  localparam int C_MEM   = 3;
  localparam int C_BUS   = 4;
  localparam int C_NOCP  = 5;
  localparam int C_STATE = 6;
  localparam int C_CHECK = 7;

  typedef enum logic [1:0] {
    CLS_HARD = 2'd0,
    CLS_MEM  = 2'd1,
    CLS_BUS  = 2'd2,
    CLS_USE  = 2'd3
  } cls_e;

  localparam int NCLS = 4;

  function automatic logic [NF-1:0] bit_of(input int idx);
    logic [NF-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  localparam logic [NF-1:0] MASK_HARD = bit_of(F_VEC);
  localparam logic [NF-1:0] MASK_MEM  = bit_of(F_MDATA) | bit_of(F_MINSTR) |
                                        bit_of(F_MSAVE) | bit_of(F_MREST);
  localparam logic [NF-1:0] MASK_BUS  = bit_of(F_BFETCH) | bit_of(F_BPREC) |
                                        bit_of(F_BSAVE) | bit_of(F_BREST);
  localparam logic [NF-1:0] MASK_USE  = bit_of(F_UNDEF) | bit_of(F_STATE) |
                                        bit_of(F_RET) | bit_of(F_UNALIGN) |
                                        bit_of(F_DIV0) | bit_of(F_NOCP);

  function automatic logic [NF-1:0] class_mask(input int c);
    case (c)
      0:       return MASK_HARD;
      1:       return MASK_MEM;
      2:       return MASK_BUS;
      default: return MASK_USE;
    endcase
  endfunction

  // debug catch category that governs each cause bit
  function automatic int cat_of(input int idx);
    case (idx)
      F_VEC, F_MSAVE, F_MREST, F_BSAVE, F_BREST: return C_STACK;
      F_FORCED:                                  return C_HARD;
      F_MDATA, F_MINSTR:                         return C_MEM;
      F_BFETCH, F_BPREC, F_BIMP:                 return C_BUS;
      F_NOCP:                                    return C_NOCP;
      F_UNDEF, F_STATE, F_RET:                   return C_STATE;
      default:                                   return C_CHECK;
    endcase
  endfunction
endpackage

// File: rtl/fru_qualify.sv
module fru_qualify
  import fru_pkg::*;
(
  input  logic [NF-1:0] cause_i,
  input  logic          ua_multi_i,
  input  logic          trap_unalign_i,
  input  logic          trap_div0_i,
  input  logic          ex_killed_i,
  output logic [NF-1:0] q_o
);
  always_comb begin
    q_o = cause_i;
    // escalation flag is produced internally only
    q_o[F_FORCED]  = 1'b0;
    // fetch errors count only for an instruction that really executes
    q_o[F_BFETCH]  = cause_i[F_BFETCH] & ~ex_killed_i;
    // multi-word misalignment always traps, single accesses on request
    q_o[F_UNALIGN] = ua_multi_i | (cause_i[F_UNALIGN] & trap_unalign_i);
    q_o[F_DIV0]    = cause_i[F_DIV0] & trap_div0_i;
  end
endmodule

// File: rtl/fru_arbiter.sv
module fru_arbiter
  import fru_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic [NF-1:0]     q_i,
  input  logic [2:0]        hnd_en_i,
  input  logic [PRIO_W-1:0] prio_mem_i,
  input  logic [PRIO_W-1:0] prio_bus_i,
  input  logic [PRIO_W-1:0] prio_use_i,
  input  logic [PRIO_W:0]   cur_prio_i,
  input  logic [NCAT-1:0]   catch_en_i,
  input  logic              slot_free_i,
  input  logic              imp_pend_i,
  output logic              take_o,
  output cls_e              take_cls_o,
  output logic              halt_o,
  output logic              forced_o,
  output logic              imp_issue_o
);
  localparam int EW = PRIO_W + 1;

  logic [NCLS-1:1][PRIO_W-1:0] cfg;
  logic [NF-1:0]               cat_hit;
  logic [NCLS-1:0]             present;
  logic [NCLS-1:0]             escal;
  logic [NCLS-1:0]             caught;
  logic [NCLS-1:0][EW-1:0]     eff;
  logic [NCLS-1:0][EW-1:0]     own_lvl;

  assign cfg = {prio_use_i, prio_bus_i, prio_mem_i};

  always_comb begin
    for (int i = 0; i < NF; i++) cat_hit[i] = catch_en_i[cat_of(i)];
  end

  // one candidate per handler class
  for (genvar g = 0; g < NCLS; g++) begin : g_cand
    assign present[g] = |(q_i & class_mask(g));
    if (g == 0) begin : g_hard
      assign own_lvl[g] = '0;
      assign escal[g]   = 1'b0;
    end else begin : g_cfg
      assign own_lvl[g] = EW'(cfg[g]) + EW'(1);
      assign escal[g]   = ~hnd_en_i[g-1] | (own_lvl[g] >= cur_prio_i);
    end
    assign eff[g]    = escal[g] ? '0 : own_lvl[g];
    assign caught[g] = (|(q_i & class_mask(g) & cat_hit)) |
                       (escal[g] & catch_en_i[C_HARD]);
  end

  logic          found;
  logic [1:0]    win;
  logic [EW-1:0] best;
  logic          imp_ok;

  always_comb begin
    found = 1'b0;
    win   = 2'd0;
    best  = '0;
    // scan from least to most preferred; <= keeps ties on the lower index
    for (int c = NCLS - 1; c >= 0; c--) begin
      if (present[c] && (!found || eff[c] <= best)) begin
        found = 1'b1;
        win   = 2'(c);
        best  = eff[c];
      end
    end
  end

  assign imp_ok = hnd_en_i[1] & (own_lvl[2] < cur_prio_i);

  always_comb begin
    take_o      = 1'b0;
    take_cls_o  = CLS_HARD;
    halt_o      = 1'b0;
    forced_o    = 1'b0;
    imp_issue_o = 1'b0;
    if (found) begin
      forced_o = escal[win];
      if (caught[win]) begin
        halt_o = 1'b1;
      end else if (slot_free_i) begin
        take_o     = 1'b1;
        take_cls_o = escal[win] ? CLS_HARD : cls_e'(win);
      end
    end else if (imp_pend_i && imp_ok) begin
      if (catch_en_i[C_BUS]) begin
        halt_o      = 1'b1;
        imp_issue_o = 1'b1;
      end else if (slot_free_i) begin
        take_o      = 1'b1;
        take_cls_o  = CLS_BUS;
        imp_issue_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fru_status.sv
module fru_status
  import fru_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic          imp_set_i,
  input  logic          imp_clr_i,
  output logic [NF-1:0] flags_o,
  output logic          imp_pend_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      flags_o    <= '0;
      imp_pend_o <= 1'b0;
    end else begin
      flags_o    <= (flags_o & ~clr_i) | set_i;
      imp_pend_o <= (imp_pend_o & ~imp_clr_i) | imp_set_i;
    end
  end
endmodule

// File: rtl/fault_route_unit.sv
module fault_route_unit
  import fru_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NF-1:0]        cause_i,
  input  logic                 ua_multi_i,
  input  logic                 trap_unalign_i,
  input  logic                 trap_div0_i,
  input  logic                 ex_killed_i,
  input  logic [2:0]           hnd_en_i,
  input  logic [PRIO_W-1:0]    prio_mem_i,
  input  logic [PRIO_W-1:0]    prio_bus_i,
  input  logic [PRIO_W-1:0]    prio_use_i,
  input  logic [PRIO_W:0]      cur_prio_i,
  input  logic [NCAT-1:0]      catch_en_i,
  input  logic [NF-1:0]        flag_clr_i,
  output logic                 exc_valid_o,
  input  logic                 exc_ready_i,
  output logic [1:0]           exc_class_o,
  output logic                 dbg_halt_o,
  output logic [NF-1:0]        status_o,
  output logic                 imp_pend_o
);
  logic [NF-1:0] q;
  logic          take, halt, forced, imp_issue, slot_free, boot_q;
  cls_e          take_cls;
  logic [NF-1:0] set_vec;

  fru_qualify u_qual (
    .cause_i        (cause_i),
    .ua_multi_i     (ua_multi_i),
    .trap_unalign_i (trap_unalign_i),
    .trap_div0_i    (trap_div0_i),
    .ex_killed_i    (ex_killed_i),
    .q_o            (q)
  );

  assign slot_free = ~exc_valid_o | exc_ready_i;

  fru_arbiter #(.PRIO_W(PRIO_W)) u_arb (
    .q_i         (q),
    .hnd_en_i    (hnd_en_i),
    .prio_mem_i  (prio_mem_i),
    .prio_bus_i  (prio_bus_i),
    .prio_use_i  (prio_use_i),
    .cur_prio_i  (cur_prio_i),
    .catch_en_i  (catch_en_i),
    .slot_free_i (slot_free),
    .imp_pend_i  (imp_pend_o),
    .take_o      (take),
    .take_cls_o  (take_cls),
    .halt_o      (halt),
    .forced_o    (forced),
    .imp_issue_o (imp_issue)
  );

  always_comb begin
    set_vec           = q;
    set_vec[F_FORCED] = forced;
  end

  fru_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .clr_i      (flag_clr_i),
    .imp_set_i  (q[F_BIMP]),
    .imp_clr_i  (imp_issue),
    .flags_o    (status_o),
    .imp_pend_o (imp_pend_o)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      exc_valid_o <= 1'b0;
      exc_class_o <= CLS_HARD;
      dbg_halt_o  <= 1'b0;
      boot_q      <= 1'b1;
    end else begin
      boot_q     <= 1'b0;
      dbg_halt_o <= halt | (boot_q & catch_en_i[C_RESET]);
      if (take) begin
        exc_valid_o <= 1'b1;
        exc_class_o <= take_cls;
      end else if (exc_ready_i) begin
        exc_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fru_checker.sv
module fru_checker
  import fru_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NF-1:0] cause_i,
  input logic          ua_multi_i,
  input logic          trap_div0_i,
  input logic          ex_killed_i,
  input logic [NF-1:0] flag_clr_i,
  input logic          exc_valid_o,
  input logic          exc_ready_i,
  input logic [1:0]    exc_class_o,
  input logic [NF-1:0] status_o
);
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_o && !exc_ready_i) |=> (exc_valid_o && $stable(exc_class_o)));

  assert_release_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(exc_valid_o) |-> $past(exc_ready_i));

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_o & ~flag_clr_i)) |=>
      ((status_o & $past(status_o & ~flag_clr_i)) == $past(status_o & ~flag_clr_i)));

  assert_killed_fetch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i[F_BFETCH] && ex_killed_i && !status_o[F_BFETCH]) |=> !status_o[F_BFETCH]);

  assert_div_untrapped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i[F_DIV0] && !trap_div0_i && !status_o[F_DIV0]) |=> !status_o[F_DIV0]);

  assert_imp_no_forced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause_i & ~bit_of(F_BIMP)) == '0 && !ua_multi_i && !status_o[F_FORCED])
      |=> !status_o[F_FORCED]);
endmodule

bind fault_route_unit fru_checker chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cause_i     (cause_i),
  .ua_multi_i  (ua_multi_i),
  .trap_div0_i (trap_div0_i),
  .ex_killed_i (ex_killed_i),
  .flag_clr_i  (flag_clr_i),
  .exc_valid_o (exc_valid_o),
  .exc_ready_i (exc_ready_i),
  .exc_class_o (exc_class_o),
  .status_o    (status_o)
);

// File: tb/fault_route_unit_tb_top.sv
module fault_route_unit_tb_top;
  localparam int PW = 3;
  localparam int NF = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NF-1:0] cause = '0, clr = '0;
  logic ua_multi = 0, trap_ua = 0, trap_dz = 0, killed = 0, ready = 1;
  logic [2:0] hnd_en = 3'b111;
  logic [PW-1:0] pm = 0, pb = 0, pu = 0;
  logic [PW:0] cur = 4'd8;
  logic [7:0] catch_en = '0;
  logic exc_valid, dbg_halt, imp_pend;
  logic [1:0] exc_class;
  logic [NF-1:0] status;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  fault_route_unit #(.PRIO_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cause_i(cause), .ua_multi_i(ua_multi),
    .trap_unalign_i(trap_ua), .trap_div0_i(trap_dz), .ex_killed_i(killed),
    .hnd_en_i(hnd_en), .prio_mem_i(pm), .prio_bus_i(pb), .prio_use_i(pu),
    .cur_prio_i(cur), .catch_en_i(catch_en), .flag_clr_i(clr),
    .exc_valid_o(exc_valid), .exc_ready_i(ready), .exc_class_o(exc_class),
    .dbg_halt_o(dbg_halt), .status_o(status), .imp_pend_o(imp_pend)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // independent model of the requirements
  function automatic int cat_for(input int i);
    if (i == 0 || i == 4 || i == 5 || i == 9 || i == 10) return 1;
    if (i == 2 || i == 3) return 3;
    if (i == 6 || i == 7 || i == 8) return 4;
    if (i == 16) return 5;
    if (i >= 11 && i <= 13) return 6;
    return 7;
  endfunction

  logic e_valid, e_halt;
  logic [1:0] e_cls;
  logic [NF-1:0] e_flags;
  string e_req;

  task automatic model();
    logic [NF-1:0] q;
    logic [NF-1:0] cm [4];
    logic [PW:0] lvl [4];
    logic pres [4];
    logic esc [4];
    logic cg [4];
    logic found;
    int w;
    cm[0] = 17'h00001; cm[1] = 17'h0003C; cm[2] = 17'h006C0; cm[3] = 17'h1F800;
    q = cause;
    q[1] = 0;
    q[6] = cause[6] & !killed;
    q[14] = ua_multi | (cause[14] & trap_ua);
    q[15] = cause[15] & trap_dz;
    found = 0; w = 0;
    for (int c = 0; c < 4; c++) begin
      logic [PW:0] p;
      p = (c == 1) ? pm + 1 : (c == 2) ? pb + 1 : pu + 1;
      pres[c] = |(q & cm[c]);
      esc[c] = (c != 0) && (!hnd_en[c-1] || p >= cur);
      lvl[c] = (c == 0 || esc[c]) ? 0 : p;
      cg[c] = esc[c] & catch_en[2];
      for (int i = 0; i < NF; i++)
        if (q[i] && cm[c][i] && catch_en[cat_for(i)]) cg[c] = 1;
    end
    for (int c = 0; c < 4; c++)
      if (pres[c] && (!found || lvl[c] < lvl[w])) begin found = 1; w = c; end
    e_valid = found && !cg[w];
    e_halt = found && cg[w];
    e_cls = (found && !esc[w]) ? 2'(w) : 2'd0;
    e_flags = q;
    e_flags[1] = found && esc[w];
    e_req = !found ? "R1" : (e_halt ? "R9" : (esc[w] ? "R4" : "R11"));
  endtask

  task automatic run_case(input string req);
    model();
    @(negedge clk);
    chk(req, "valid", 32'(exc_valid), 32'(e_valid));
    if (e_valid) chk(req, "class", 32'(exc_class), 32'(e_cls));
    chk(req, "halt", 32'(dbg_halt), 32'(e_halt));
    chk(req, "flags", 32'(status), 32'(e_flags));
    cause = '0; ua_multi = 0; clr = '1;
    @(negedge clk);
    clr = '0;
  endtask

  task automatic do_reset();
    rst_n = 0; cause = '0; ua_multi = 0; clr = '0; ready = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R13", "valid", 32'(exc_valid), 0);
    chk("R13", "halt", 32'(dbg_halt), 0);
    chk("R13", "status", 32'(status), 0);
    chk("R13", "pend", 32'(imp_pend), 0);

    // reset catch
    catch_en = 8'h01;
    do_reset();
    @(negedge clk);
    chk("R9", "reset halt", 32'(dbg_halt), 1);
    @(negedge clk);
    chk("R9", "reset halt end", 32'(dbg_halt), 0);
    catch_en = '0;

    // single-cause sweep over enable, priority and current level
    trap_ua = 1; trap_dz = 1;
    for (int c = 0; c < NF; c++)
      for (int e = 0; e < 2; e++)
        for (int pi = 0; pi < 3; pi++)
          for (int cv = 0; cv <= 8; cv++) begin
            logic [PW-1:0] pv;
            pv = (pi == 0) ? 3'd0 : (pi == 1) ? 3'd3 : 3'd7;
            pm = pv; pb = pv; pu = pv; cur = 4'(cv);
            hnd_en = e ? 3'b111 : 3'b000;
            cause = '0; cause[c] = 1;
            if (c == 0) run_case("R2");
            else if (c == 4 || c == 5 || c == 9 || c == 10) run_case("R3");
            else if (c == 8) begin
              run_case("R5");
              do_reset();
            end else begin
              model();
              run_case(e_req);
            end
          end

    // qualification conditions
    hnd_en = 3'b111; pm = 1; pb = 1; pu = 1; cur = 8;
    for (int k = 0; k < 2; k++) begin
      killed = k[0]; cause = '0; cause[6] = 1; run_case("R6");
    end
    killed = 0;
    for (int k = 0; k < 8; k++) begin
      ua_multi = k[0]; trap_ua = k[1]; cause = '0; cause[14] = k[2];
      run_case("R7");
    end
    for (int k = 0; k < 2; k++) begin
      trap_dz = k[0]; cause = '0; cause[15] = 1; run_case("R8");
    end
    trap_ua = 1; trap_dz = 1;

    // same-cycle arbitration across class pairs and priorities
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++)
        for (int pp = 0; pp < 64; pp++) begin
          int rep [4];
          rep[0] = 0; rep[1] = 2; rep[2] = 7; rep[3] = 11;
          pm = 3'(pp % 4); pb = 3'((pp / 4) % 4); pu = 3'(pp / 16);
          cur = (pp % 5 == 0) ? 4'd2 : 4'd8;
          cause = '0; cause[rep[a]] = 1; cause[rep[b]] = 1;
          run_case("R11");
        end

    // debug catch per category, own and escalated
    pm = 2; pb = 2; pu = 2; cur = 8;
    for (int e = 0; e < 2; e++)
      for (int c = 0; c < NF; c++)
        for (int k = 1; k < 8; k++) begin
          if (c == 1 || c == 8) continue;
          hnd_en = e ? 3'b111 : 3'b000;
          catch_en = '0; catch_en[k] = 1;
          cause = '0; cause[c] = 1;
          run_case("R9");
        end
    catch_en = '0; hnd_en = 3'b111;

    // sticky flags and write-one-to-clear
    cause = '0; cause[2] = 1;
    @(negedge clk);
    cause = '0; cause[7] = 1;
    @(negedge clk);
    cause = '0;
    chk("R10", "both sticky", 32'(status & 17'h84), 32'h84);
    clr = 17'h4;
    @(negedge clk);
    chk("R10", "clear one", 32'(status), 32'h80);
    clr = 17'h80; cause[7] = 1;
    @(negedge clk);
    chk("R10", "set beats clear", 32'(status), 32'h80);
    cause = '0; clr = '1;
    @(negedge clk);
    clr = '0;
    chk("R10", "cleared", 32'(status), 0);

    // back-pressure on the request channel
    ready = 0; cause = '0; cause[2] = 1;
    @(negedge clk);
    cause = '0; cause[7] = 1;
    chk("R12", "valid", 32'(exc_valid), 1);
    chk("R12", "class", 32'(exc_class), 1);
    @(negedge clk);
    cause = '0;
    chk("R12", "held valid", 32'(exc_valid), 1);
    chk("R12", "held class", 32'(exc_class), 1);
    chk("R12", "late flag", 32'(status[7]), 1);
    ready = 1;
    @(negedge clk);
    chk("R12", "released", 32'(exc_valid), 0);
    clr = '1;
    @(negedge clk);
    clr = '0;

    // imprecise error issued later as bus class
    do_reset();
    pb = 2; cur = 8; hnd_en = 3'b111;
    cause = '0; cause[8] = 1;
    @(negedge clk);
    cause = '0;
    chk("R5", "no sync req", 32'(exc_valid), 0);
    chk("R5", "pend", 32'(imp_pend), 1);
    chk("R5", "flag", 32'(status), 32'h100);
    @(negedge clk);
    chk("R5", "issued", 32'(exc_valid), 1);
    chk("R5", "class", 32'(exc_class), 2);
    chk("R5", "pend cleared", 32'(imp_pend), 0);
    chk("R5", "no forced", 32'(status[1]), 0);

    // imprecise held behind a disabled handler, then racing a sync fault
    do_reset();
    hnd_en = 3'b101; pu = 1;
    cause = '0; cause[8] = 1;
    @(negedge clk);
    cause = '0;
    repeat (3) @(negedge clk);
    chk("R5", "still pending", 32'(imp_pend), 1);
    chk("R5", "no request", 32'(exc_valid), 0);
    chk("R5", "never forced", 32'(status[1]), 0);
    hnd_en = 3'b111; cause[11] = 1;
    @(negedge clk);
    cause = '0;
    chk("R11", "sync first", 32'(exc_class), 3);
    chk("R11", "sync valid", 32'(exc_valid), 1);
    chk("R5", "pend survives", 32'(imp_pend), 1);
    @(negedge clk);
    chk("R5", "then bus", 32'(exc_class), 2);
    chk("R5", "then valid", 32'(exc_valid), 1);
    chk("R5", "drained", 32'(imp_pend), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule